// File: doc/BRIEF.md
# Multichannel Transmit Pulse Sequencer

This block times one transmit event of an eight-channel ultrasonic pulser. Every channel holds two bit patterns, one for the positive trigger and one for the negative trigger. It also holds a firing delay and a pattern-length choice. A rising edge on the transmit-enable input starts all channels on the same clock edge. Each channel first waits out its own coarse delay, counted in core clock cycles. It then plays its pattern from bit 0 upward, and each bit lasts two core cycles, which is half the core clock rate.

The sub-cycle part of each delay is not applied here. It is presented as a 3-bit code per channel, in eighths of a core cycle, for a downstream analog delay line. The code is held steady for the whole firing.

A simple write port fills a set of shadow settings at any time. A firing copies the shadow settings into the channels when it starts, so the next scan zone can be loaded while the current one is still transmitting.

Top module: `tx_pulse_seq`

## Requirements
- R1: After reset, every trigger output, the busy output, every conflict flag and every fine code read 0.
- R2: A firing starts only at the clock edge that first samples transmit-enable high after it was low, and only while busy is low. While busy is low, no trigger output is high.
- R3: A channel with coarse delay C (0 to 16383) drives its pattern bit 0 starting C+1 cycles after the start edge.
- R4: Pattern bits are played from bit 0 upward, and each bit is held for exactly 2 core cycles.
- R5: A 1 in bit b of the positive pattern drives that channel's positive trigger during bit slot b. A 1 in the negative pattern drives the negative trigger. The two patterns are independent.
- R6: The length selector value 0 plays bits 0 to 3 only, and any higher pattern bits have no effect. The value 1 plays bits 0 to 63.
- R7: Each channel's 3-bit fine code is taken at the start edge and stays unchanged on its output until the next firing starts.
- R8: Busy goes high the cycle after the start edge and stays high until the slowest channel has played its last bit. Further rising edges of transmit-enable while busy is high start nothing. A transmit-enable held high past the end of a firing starts nothing.
- R9: If bit slot b has a 1 in both patterns, neither trigger is driven for that slot. The channel's conflict flag rises one cycle after the slot begins and stays high until reset.
- R10: Writes at any time go to shadow settings. They do not alter a firing in progress, and they are used from the next start edge onward.
- R11: A write selects a setting with wr_sel: 0 is the positive pattern (wr_data[63:0]), 1 is the negative pattern, 2 is the delay (wr_data[2:0] fine code, wr_data[16:3] coarse count) and 3 is the length (wr_data[0]). The setting written belongs to channel wr_ch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Shadow setting write strobe |
| wr_ch | input | 3 | Channel written |
| wr_sel | input | 2 | Setting selector |
| wr_data | input | 64 | Write data |
| tx_en | input | 1 | Transmit enable; its rising edge starts a firing |
| busy_o | output | 1 | A firing is in progress |
| pos_o | output | 8 | Positive trigger, one per channel |
| neg_o | output | 8 | Negative trigger, one per channel |
| fine_o | output | 24 | Fine delay codes, 3 bits per channel, channel 0 in the low bits |
| conflict_o | output | 8 | Sticky per-channel conflict flags |

## Verification
Short patterns on staggered delays have extra high bits set. Only a correct length cut and a correct delay offset produce the expected edges on each channel. Long patterns with unlike halves, plus single bits at slots 0 and 63, catch errors in bit order and in the end-of-pattern index. One overlapped slot tells a suppressed pulse apart from a missing flag. A retrigger during a firing and a transmit-enable held high past the end tell edge detection apart from level sensing. A write in the middle of a firing followed by a second firing shows whether the shadow settings are isolated. A channel at the largest coarse count checks the full delay width.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;
    localparam int NCH       = 8;
    localparam int PAT_W     = 64;
    localparam int SHORT_LEN = 4;
    localparam int CRS_W     = 14;
    localparam int FINE_W    = 3;
    localparam int BIT_CYC   = 2;
    localparam int IDX_W     = $clog2(PAT_W);
    localparam int CH_W      = $clog2(NCH);
    localparam int PH_W      = $clog2(BIT_CYC);

    typedef enum logic [1:0] {
        SEL_POS = 2'd0,
        SEL_NEG = 2'd1,
        SEL_DLY = 2'd2,
        SEL_LEN = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_WAIT,
        CH_EMIT
    } chan_st_e;

    typedef struct packed {
        logic [PAT_W-1:0]  pos;
        logic [PAT_W-1:0]  neg;
        logic [CRS_W-1:0]  coarse;
        logic [FINE_W-1:0] fine;
        logic              long_len;
    } chan_cfg_t;

    function automatic logic [IDX_W-1:0] last_idx(input logic long_len);
        return long_len ? IDX_W'(PAT_W - 1) : IDX_W'(SHORT_LEN - 1);
    endfunction
endpackage

// File: rtl/tx_seq_shadow.sv
module tx_seq_shadow
    import tx_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [CH_W-1:0]           wr_ch,
    input  wr_sel_e                   wr_sel,
    input  logic [PAT_W-1:0]          wr_data,
    output chan_cfg_t [NCH-1:0]       cfg_o
);
    chan_cfg_t [NCH-1:0] bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_POS: bank[wr_ch].pos <= wr_data;
                SEL_NEG: bank[wr_ch].neg <= wr_data;
                SEL_DLY: begin
                    bank[wr_ch].fine   <= wr_data[FINE_W-1:0];
                    bank[wr_ch].coarse <= wr_data[FINE_W +: CRS_W];
                end
                default: bank[wr_ch].long_len <= wr_data[0];
            endcase
        end
    end

    assign cfg_o = bank;
endmodule

// File: rtl/tx_seq_chan.sv
module tx_seq_chan
    import tx_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  chan_cfg_t         cfg_i,
    output logic              pos_o,
    output logic              neg_o,
    output logic              act_o,
    output logic              conflict_o,
    output logic [FINE_W-1:0] fine_o
);
    chan_cfg_t        act;
    chan_st_e         st;
    logic [CRS_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [PH_W-1:0]  ph;
    logic             conf;
    logic             bit_p, bit_n, emitting;

    assign bit_p    = act.pos[idx];
    assign bit_n    = act.neg[idx];
    assign emitting = (st == CH_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= '0;
            st   <= CH_IDLE;
            cnt  <= '0;
            idx  <= '0;
            ph   <= '0;
            conf <= 1'b0;
        end else begin
            if (start) begin
                act <= cfg_i;
                cnt <= cfg_i.coarse;
                st  <= CH_WAIT;
            end else begin
                case (st)
                    CH_WAIT: begin
                        if (cnt == '0) begin
                            st  <= CH_EMIT;
                            idx <= '0;
                            ph  <= '0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    CH_EMIT: begin
                        if (ph == PH_W'(BIT_CYC - 1)) begin
                            ph <= '0;
                            if (idx == last_idx(act.long_len)) st <= CH_IDLE;
                            else idx <= idx + 1'b1;
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
            if (emitting && bit_p && bit_n) conf <= 1'b1;
        end
    end

    assign pos_o      = emitting && bit_p && !bit_n;
    assign neg_o      = emitting && bit_n && !bit_p;
    assign act_o      = (st != CH_IDLE);
    assign conflict_o = conf;
    assign fine_o     = act.fine;
endmodule

// File: rtl/tx_pulse_seq.sv
module tx_pulse_seq
    import tx_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [CH_W-1:0]       wr_ch,
    input  logic [1:0]            wr_sel,
    input  logic [PAT_W-1:0]      wr_data,
    input  logic                  tx_en,
    output logic                  busy_o,
    output logic [NCH-1:0]        pos_o,
    output logic [NCH-1:0]        neg_o,
    output logic [NCH*FINE_W-1:0] fine_o,
    output logic [NCH-1:0]        conflict_o
);
    chan_cfg_t [NCH-1:0] shadow;
    logic [NCH-1:0]      act;
    logic                tx_en_q;
    logic                start;

    tx_seq_shadow shadow_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_sel  (wr_sel_e'(wr_sel)),
        .wr_data (wr_data),
        .cfg_o   (shadow)
    );

    always_ff @(posedge clk) begin
        if (rst) tx_en_q <= 1'b0;
        else     tx_en_q <= tx_en;
    end

    assign busy_o = |act;
    assign start  = tx_en && !tx_en_q && !busy_o;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tx_seq_chan chan_i (
            .clk        (clk),
            .rst        (rst),
            .start      (start),
            .cfg_i      (shadow[g]),
            .pos_o      (pos_o[g]),
            .neg_o      (neg_o[g]),
            .act_o      (act[g]),
            .conflict_o (conflict_o[g]),
            .fine_o     (fine_o[g*FINE_W +: FINE_W])
        );
    end
endmodule

// File: rtl/tx_seq_chk.sv
module tx_seq_chk
    import tx_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  tx_en,
    input logic                  busy_o,
    input logic [NCH-1:0]        pos_o,
    input logic [NCH-1:0]        neg_o,
    input logic [NCH*FINE_W-1:0] fine_o,
    input logic [NCH-1:0]        conflict_o
);
    AST_TRIG_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pos_o & neg_o) == '0);                                          // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> ((pos_o | neg_o) == '0));                            // R2
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($rose(tx_en) && !busy_o) |=> busy_o);                           // R8
    AST_FINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |-> $stable(fine_o));                  // R7
    AST_CONF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ($past(conflict_o) & ~conflict_o) == '0);                        // R9

    for (genvar g = 0; g < NCH; g++) begin : g_w
        AST_POS_WIDTH: assert property (@(posedge clk) disable iff (rst)
            $rose(pos_o[g]) |=> pos_o[g]);                               // R4
        AST_NEG_WIDTH: assert property (@(posedge clk) disable iff (rst)
            $rose(neg_o[g]) |=> neg_o[g]);                               // R4
    end
endmodule

bind tx_pulse_seq tx_seq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .busy_o     (busy_o),
    .pos_o      (pos_o),
    .neg_o      (neg_o),
    .fine_o     (fine_o),
    .conflict_o (conflict_o)
);

// File: tb/tx_pulse_seq_tb_top.sv
module tx_pulse_seq_tb_top;
    import tx_seq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_ch = '0;
    logic [1:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic        tx_en = 1'b0;
    logic        busy_o;
    logic [7:0]  pos_o, neg_o, conflict_o;
    logic [23:0] fine_o;

    tx_pulse_seq dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .tx_en(tx_en), .busy_o(busy_o), .pos_o(pos_o),
        .neg_o(neg_o), .fine_o(fine_o), .conflict_o(conflict_o)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          stamp;
        logic        busy;
        logic [7:0]  pos, neg, conf;
        logic [23:0] fine;
        string       tag;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0;

    logic [63:0] m_pos [8];
    logic [63:0] m_neg [8];
    int          m_crs [8];
    logic [2:0]  m_fine [8];
    bit          m_long [8];
    logic [7:0]  m_conf = '0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp == cyc) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " R8 R2"}, "busy", 64'(busy_o), 64'(e.busy));
            chk({e.tag, " R3 R4 R5 R6"}, "pos", 64'(pos_o), 64'(e.pos));
            chk({e.tag, " R3 R4 R5 R6"}, "neg", 64'(neg_o), 64'(e.neg));
            chk({e.tag, " R9"}, "conflict", 64'(conflict_o), 64'(e.conf));
            chk({e.tag, " R7"}, "fine", 64'(fine_o), 64'(e.fine));
        end
    end

    // R11: selector 0 pos, 1 neg, 2 delay {coarse[16:3], fine[2:0]}, 3 length bit 0
    task automatic wr(int ch, int sel, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 3'(ch); wr_sel = 2'(sel); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            0: m_pos[ch] = d;
            1: m_neg[ch] = d;
            2: begin m_fine[ch] = d[2:0]; m_crs[ch] = int'(d[16:3]); end
            default: m_long[ch] = d[0];
        endcase
    endtask

    task automatic setch(int ch, logic [63:0] p, logic [63:0] n, int crs, int fine, bit lng);
        wr(ch, 0, p);
        wr(ch, 1, n);
        wr(ch, 2, (64'(crs) << 3) | 64'(fine));
        wr(ch, 3, 64'(lng));
    endtask

    // drive one firing and push the expected output of every cycle
    task automatic fire(bit hold, int tail, string tag);
        logic [63:0] sp [8];
        logic [63:0] sn [8];
        int          sc [8];
        int          sl [8];
        logic [23:0] sf;
        int          base, kmax;
        @(negedge clk);
        tx_en = 1'b1;
        base  = cyc + 1;
        kmax  = 0;
        sf    = '0;
        for (int c = 0; c < 8; c++) begin
            sp[c] = m_pos[c]; sn[c] = m_neg[c]; sc[c] = m_crs[c];
            sl[c] = m_long[c] ? 64 : 4;
            sf[c*3 +: 3] = m_fine[c];
            if (sc[c] + 2*sl[c] > kmax) kmax = sc[c] + 2*sl[c];
        end
        for (int k = 0; k <= kmax + tail; k++) begin
            exp_t e;
            e.stamp = base + k; e.busy = 1'b0; e.pos = '0; e.neg = '0;
            e.fine = sf; e.tag = tag;
            for (int c = 0; c < 8; c++) begin
                if (k <= sc[c] + 2*sl[c]) e.busy = 1'b1;
                if (k >= sc[c] + 1 && k <= sc[c] + 2*sl[c]) begin
                    int b;
                    b = (k - sc[c] - 1) / 2;
                    e.pos[c] = sp[c][b] & ~sn[c][b];
                    e.neg[c] = sn[c][b] & ~sp[c][b];
                end
                if (k - 1 >= sc[c] + 1 && k - 1 <= sc[c] + 2*sl[c]) begin
                    int b;
                    b = (k - 1 - sc[c] - 1) / 2;
                    if (sp[c][b] && sn[c][b]) m_conf[c] = 1'b1;
                end
            end
            e.conf = m_conf;
            q.push_back(e);
        end
        if (!hold) begin
            @(negedge clk);
            tx_en = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        for (int c = 0; c < 8; c++) begin
            m_pos[c] = '0; m_neg[c] = '0; m_crs[c] = 0; m_fine[c] = '0; m_long[c] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 64'(busy_o), 64'd0);
        chk("R1", "pos", 64'(pos_o), 64'd0);
        chk("R1", "neg", 64'(neg_o), 64'd0);
        chk("R1", "conflict", 64'(conflict_o), 64'd0);
        chk("R1", "fine", 64'(fine_o), 64'd0);

        // R6 R3 R7: short patterns with junk high bits, staggered delays
        for (int c = 0; c < 8; c++) begin
            logic [63:0] p;
            p = (c % 2) ? 64'h5 : 64'hA;
            setch(c, p | 64'hFF00, ~p & 64'hF | 64'hF0_0000, c * 3, c, 1'b0);
        end
        fire(1'b0, 3, "R6 short");

        // R4 R5 R6: long patterns, bit order and end index
        setch(0, 64'hA5A5_0F0F_3C3C_8001, ~64'hA5A5_0F0F_3C3C_8001, 2, 5, 1'b1);
        setch(1, 64'h1, 64'h8000_0000_0000_0000, 0, 1, 1'b1);
        fire(1'b0, 2, "R4 long");

        // R9 + R8 retrigger ignored during a firing
        setch(3, 64'h6, 64'h3, 1, 4, 1'b0);
        fork
            fire(1'b0, 4, "R9 R8 retrig");
            begin
                repeat (4) @(negedge clk);
                tx_en = 1'b1;
                @(negedge clk);
                tx_en = 1'b0;
            end
        join

        // R10: write in mid-firing, held tx_en past end (R8)
        fork
            fire(1'b0, 2, "R10 shadow");
            begin
                repeat (3) @(negedge clk);
                wr(0, 0, 64'h0000_0000_0000_00F0);
                wr(0, 3, 64'd0);
            end
        join
        fire(1'b1, 6, "R10 R8 hold");

        // R3: largest coarse count
        setch(7, 64'h9, 64'h6, 16383, 7, 1'b0);
        fire(1'b0, 2, "R3 maxdelay");

        summary();
    end
endmodule